// File: doc/BRIEF.md
# Shared-Prescaler Input Debounce Filter

This block cleans up slow, bouncy input lines before they reach edge and level interrupt detection. It sits between the input synchronisers and the interrupt detector. One programmable prescaler divides the bus clock into a slow sampling tick, and every line uses that same tick. A line is filtered only when both its debounce enable bit and its interrupt enable bit are set. A filtered line takes a new value only after the input has shown that value on two sampling ticks in a row. Any other line passes its synchronised input straight through, with no register in the path.

The divisor and the two enable vectors arrive as plain inputs; register decoding happens elsewhere. As an example, a divisor of 2000 on a 66 MHz bus clock samples at about 33 kHz. Each line keeps a filtered value and one pending bit. While a line is not filtered, its filtered value follows the input, so turning filtering on never exposes a stale value. Writing a different divisor restarts the prescale count.

Top module: `gpio_debounce`

## Requirements
- R1: While rst_n is low, line_out_o equals line_in_i on every line, whatever the enables are. Reset clears the prescale counter, the stored divisor (to 0), every filtered value and every pending bit.
- R2: A line whose debounce enable bit or interrupt enable bit is 0 drives line_out_o equal to line_in_i in the same cycle.
- R3: With a divisor P of 2 or more held steady, the sampling tick occurs once every P clock cycles. The first tick comes P cycles after the cycle in which the divisor was taken.
- R4: A steady divisor of 0 or 1 gives a sampling tick on every clock cycle.
- R5: A filtered line (both enable bits 1) changes its output only at a tick where the input differs from the output and also differed at the previous tick. The output takes the input value in the cycle after that tick.
- R6: A tick at which a filtered line's input equals its output cancels any pending change on that line. A pulse seen at only one tick is therefore rejected.
- R7: In a cycle where prescale_i differs from the stored divisor, the new value is stored, the counter restarts from zero and no tick occurs.
- R8: All lines share one tick, but each line keeps its own filtered value and pending state.
- R9: While a line is not filtered, its filtered value loads the input every cycle and its pending bit is cleared. Once filtering is enabled, the output shows the input from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_i | input | PRE_W | Clock divisor for the sampling tick |
| line_in_i | input | LINES | Synchronised input lines |
| deb_en_i | input | LINES | Per-line debounce enable |
| irq_en_i | input | LINES | Per-line interrupt enable; filtering needs it set |
| line_out_o | output | LINES | Filtered or bypassed lines |

## Verification
The hardest case to reach from the ports is a line whose input disagrees with its output at exactly one tick and has returned by the next. A rejected glitch and a committed change differ only in where the input edges fall relative to a tick that the ports do not show. The stimulus therefore holds random values for random spans of one to several divisor periods. It runs the same patterns with divisors 0, 1, 3 and 5, and rewrites the divisor partway through a count. A cycle model of the tick and of each line's pending bit predicts every output value.

// File: rtl/gpio_debounce_pkg.sv
package gpio_debounce_pkg;

    typedef enum logic [1:0] {
        CELL_TRACK  = 2'd0,
        CELL_IDLE   = 2'd1,
        CELL_ARM    = 2'd2,
        CELL_COMMIT = 2'd3
    } cell_act_e;

    localparam int DEF_LINES = 32;
    localparam int DEF_PRE_W = 24;

endpackage

// File: rtl/gpio_debounce_tick.sv
module gpio_debounce_tick
    import gpio_debounce_pkg::*;
#(
    parameter int PRE_W = DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             tick_o,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] div_o
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     tick_d;

    always_comb begin
        st_d   = st_q;
        tick_d = 1'b0;
        if (prescale_i != st_q.div) begin
            st_d.div = prescale_i;
            st_d.cnt = '0;
        end else if (st_q.div <= ONE) begin
            tick_d   = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.cnt == st_q.div - ONE) begin
            tick_d   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick_d;
    assign cnt_o  = st_q.cnt;
    assign div_o  = st_q.div;
endmodule

// File: rtl/gpio_debounce_cell.sv
module gpio_debounce_cell
    import gpio_debounce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic act_i,
    input  logic in_i,
    output logic out_o,
    output logic filt_o,
    output logic pend_o
);
    typedef struct packed {
        logic filt;
        logic pend;
    } cell_st_t;

    cell_st_t  st_d, st_q;
    cell_act_e act_sel;

    always_comb begin
        if (!act_i) begin
            act_sel = CELL_TRACK;
        end else if (!tick_i || (in_i == st_q.filt)) begin
            act_sel = CELL_IDLE;
        end else if (st_q.pend) begin
            act_sel = CELL_COMMIT;
        end else begin
            act_sel = CELL_ARM;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act_sel)
            CELL_TRACK: begin
                st_d.filt = in_i;
                st_d.pend = 1'b0;
            end
            CELL_IDLE: begin
                if (tick_i) begin
                    st_d.pend = 1'b0;
                end
            end
            CELL_ARM: begin
                st_d.pend = 1'b1;
            end
            CELL_COMMIT: begin
                st_d.filt = in_i;
                st_d.pend = 1'b0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o  = (act_i && rst_n) ? st_q.filt : in_i;
    assign filt_o = st_q.filt;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_debounce_pkg::*;
#(
    parameter int LINES = DEF_LINES,
    parameter int PRE_W = DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [LINES-1:0] line_in_i,
    input  logic [LINES-1:0] deb_en_i,
    input  logic [LINES-1:0] irq_en_i,
    output logic [LINES-1:0] line_out_o
);
    logic             tick_w;
    logic [PRE_W-1:0] cnt_w;
    logic [PRE_W-1:0] div_w;
    logic [LINES-1:0] act_w;
    logic [LINES-1:0] filt_w;
    logic [LINES-1:0] pend_w;

    assign act_w = deb_en_i & irq_en_i;

    gpio_debounce_tick #(.PRE_W(PRE_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale_i (prescale_i),
        .tick_o     (tick_w),
        .cnt_o      (cnt_w),
        .div_o      (div_w)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        gpio_debounce_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_w),
            .act_i  (act_w[g]),
            .in_i   (line_in_i[g]),
            .out_o  (line_out_o[g]),
            .filt_o (filt_w[g]),
            .pend_o (pend_w[g])
        );
    end
endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
    parameter int LINES = 32,
    parameter int PRE_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PRE_W-1:0] prescale_i,
    input logic [LINES-1:0] line_in_i,
    input logic [LINES-1:0] line_out_o,
    input logic [LINES-1:0] act_w,
    input logic             tick_w,
    input logic [PRE_W-1:0] cnt_w,
    input logic [PRE_W-1:0] div_w,
    input logic [LINES-1:0] filt_w,
    input logic [LINES-1:0] pend_w
);
    AST_RESET_PASS: assert property (@(posedge clk)
        !rst_n |-> (line_out_o == line_in_i)); // R1

    AST_BYPASS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_out_o ^ line_in_i) & ~act_w) == '0); // R2

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div_w > PRE_W'(1)) |-> (cnt_w < div_w)); // R3

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_w) |-> (((filt_w ^ $past(filt_w)) & $past(act_w)) == '0)); // R5

    AST_COMMIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_w ^ $past(filt_w)) & $past(act_w) & ~$past(pend_w)) == '0); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_i != div_w) |=> (cnt_w == '0)); // R7

    AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prescale_i != div_w) |-> !tick_w); // R7
endmodule

bind gpio_debounce gpio_debounce_chk #(.LINES(LINES), .PRE_W(PRE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prescale_i (prescale_i),
    .line_in_i  (line_in_i),
    .line_out_o (line_out_o),
    .act_w      (act_w),
    .tick_w     (tick_w),
    .cnt_w      (cnt_w),
    .div_w      (div_w),
    .filt_w     (filt_w),
    .pend_w     (pend_w)
);

// File: tb/gpio_debounce_bench.sv
`timescale 1ns/1ps
module gpio_debounce_bench;
    localparam int N  = 32;
    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pre = '0;
    logic [N-1:0]  din = '0;
    logic [N-1:0]  den = '0;
    logic [N-1:0]  ien = '0;
    logic [N-1:0]  dout;

    always #5 clk = ~clk;

    gpio_debounce #(.LINES(N), .PRE_W(PW)) u_gpio_debounce (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale_i (pre),
        .line_in_i  (din),
        .deb_en_i   (den),
        .irq_en_i   (ien),
        .line_out_o (dout)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    logic [PW-1:0] m_cnt  = '0;
    logic [PW-1:0] m_div  = '0;
    logic [N-1:0]  m_filt = '0;
    logic [N-1:0]  m_pend = '0;

    // Driver: applies one cycle of stimulus, predicts the output, advances the model
    task automatic step(input logic r, input logic [PW-1:0] p, input logic [N-1:0] d,
                        input logic [N-1:0] e, input logic [N-1:0] ie, input string tag);
        logic [N-1:0] act;
        logic [N-1:0] exp;
        logic         tk;
        @(negedge clk);
        rst_n = r; pre = p; din = d; den = e; ien = ie;
        act = e & ie;
        if (!r) begin
            exp = d;
            m_cnt = '0; m_div = '0; m_filt = '0; m_pend = '0;
        end else begin
            exp = (act & m_filt) | (~act & d);
            if (p != m_div) begin
                tk = 1'b0; m_div = p; m_cnt = '0;
            end else if (p <= PW'(1)) begin
                tk = 1'b1; m_cnt = '0;
            end else if (m_cnt == p - PW'(1)) begin
                tk = 1'b1; m_cnt = '0;
            end else begin
                tk = 1'b0; m_cnt = m_cnt + PW'(1);
            end
            for (int i = 0; i < N; i++) begin
                if (!act[i]) begin
                    m_filt[i] = d[i]; m_pend[i] = 1'b0;
                end else if (tk) begin
                    if (d[i] == m_filt[i]) m_pend[i] = 1'b0;
                    else if (m_pend[i]) begin m_filt[i] = d[i]; m_pend[i] = 1'b0; end
                    else m_pend[i] = 1'b1;
                end
            end
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the output shortly before each rising edge
    initial begin
        logic [N-1:0] e;
        string        t;
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (dout !== e) begin
                    n_bad++;
                    $display("FAIL %s: line_out=%h expected %h", t, dout, e);
                end
            end
        end
    end

    // Random stimulus: values held for 1..hmax cycles
    task automatic run_held(input logic [PW-1:0] p, input int cycles, input int hmax,
                            input logic [N-1:0] e, input logic [N-1:0] ie, input string tag);
        logic [N-1:0] v;
        int hold;
        v = $urandom;
        hold = 0;
        for (int c = 0; c < cycles; c++) begin
            if (hold == 0) begin
                v = $urandom;
                hold = 1 + ($urandom % hmax);
            end
            hold--;
            step(1'b1, p, v, e, ie, tag);
        end
    endtask

    initial begin
        logic [N-1:0] ones;
        ones = '1;
        for (int k = 0; k < 4; k++) step(1'b0, PW'(5), $urandom, ones, ones, "R1 reset bypass");
        for (int k = 0; k < 12; k++) step(1'b1, PW'(7), $urandom, '0, ones, "R2 debounce enable clear");
        for (int k = 0; k < 12; k++) step(1'b1, PW'(7), $urandom, ones, '0, "R2 irq enable clear");
        for (int k = 0; k < 4; k++) step(1'b1, PW'(7), 32'hA5A5_0F0F, '0, '0, "R9 tracking");
        for (int k = 0; k < 4; k++) step(1'b1, PW'(7), 32'hA5A5_0F0F, ones, ones, "R9 enable on");
        run_held(PW'(0), 60, 3, ones, ones, "R4 divisor zero");
        run_held(PW'(1), 60, 3, ones, ones, "R4 divisor one");
        run_held(PW'(5), 200, 14, ones, ones, "R3 R5 two ticks period five");
        run_held(PW'(5), 150, 6, ones, ones, "R6 glitch rejection");
        for (int k = 0; k < 6; k++) begin
            run_held(PW'(4 + k), 3 + k, 2, ones, ones, "R7 divisor rewrite");
        end
        run_held(PW'(6), 40, 12, ones, ones, "R7 after rewrite");
        run_held(PW'(3), 150, 8, 32'h0F0F_33CC, 32'hFF00_FF0F, "R8 mixed lines");
        for (int k = 0; k < 20; k++) begin
            run_held(PW'(3), 8, 5, $urandom, $urandom, "R8 R9 changing enables");
        end
        step(1'b0, PW'(3), 32'h1234_5678, ones, ones, "R1 reset mid-run");
        step(1'b0, PW'(3), 32'h8765_4321, ones, ones, "R1 reset mid-run");
        run_held(PW'(2), 30, 4, ones, ones, "R1 R5 after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule